// File: doc/BRIEF.md
# SPI Response Tag Locator

This block watches the bytes that come back from a wireless-module SPI slave and finds the frame marker the host is waiting for. It has two jobs. In data-hunt mode it looks for the marker that comes before read data: any byte whose upper nibble is 0xF. It skips a variable run of padding bytes to get there. In write-response mode it takes a fixed four-byte window after a block write. It then picks the latest two-byte response in that window, so that a stale response left over from an earlier packet is passed over.

A one-cycle `start` pulse arms a new search. The mode and the window length are latched from the inputs on that pulse. Bytes are offered with `in_valid`, and only bytes taken after the pulse count. The block then raises `done` together with either `found` or `err`. It also reports where the marker sat, the marker byte, its packet-type nibble and the status byte. These results hold until the next `start` pulse. Bit shifting and CRC checking are handled elsewhere.

Top module: `spi_tag_locator`

## Requirements
- R1: After reset, `done`, `found` and `err` are 0, and `tag_idx`, `tag_byte`, `pkt_type` and `status_byte` are all zero.
- R2: In data-hunt mode (`wr_mode`=0), the first taken byte whose bits 7:4 equal 0xF ends the search. The block then shows `done`=1, `found`=1, `tag_byte` equal to that byte, `status_byte`=0x00 and `tag_idx` equal to the byte's position. Position 0 is the first byte taken after `start`. These outputs appear one clock after the edge that takes the byte.
- R3: In data-hunt mode, taken bytes whose upper nibble is not 0xF are skipped as padding. This holds whatever their value, including 0x00.
- R4: With `long_hunt`=0, the data hunt window is SHORT_WIN (default 8) bytes. A marker at the last position is still found. If no marker appears in the window, the block shows `done`=1 and `err`=1 after the last window byte, with `tag_idx`, `tag_byte` and `status_byte` at zero.
- R5: With `long_hunt`=1, the data hunt window is LONG_WIN (default 101) bytes: one first poll plus 100 retries. The hunt does not end after SHORT_WIN bytes.
- R6: A cycle with `in_valid`=0 neither advances the window nor can supply a marker.
- R7: In write-response mode (`wr_mode`=1), exactly RSP_BYTES (default 4) taken bytes are collected. The result appears one clock after the edge that takes the last of them.
- R8: In write-response mode, the header is the highest-indexed byte among positions RSP_BYTES-2 down to 0 whose bits 7:4 equal 0xC. `tag_idx` is its position, `tag_byte` is the header and `status_byte` is the byte after it. The last position is never taken as a header. If no such byte exists, `tag_idx`, `tag_byte` and `status_byte` are zero.
- R9: A write response is accepted (`found`=1) only when the header's packet type, bits 3:0, is 3 (last packet) and the status byte is 0x00. The other type codes are 1 (first) and 2 (inner). Any other case gives `err`=1, and the located header and status are still reported.
- R10: Once `done` is 1, all result outputs hold their values and further bytes are ignored until the next `start`.
- R11: A `start` pulse clears `done`, `found` and `err` by the next clock and restarts the window, even in the middle of a search. A byte offered in the same cycle as `start` is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that arms a new search and latches the mode |
| wr_mode | input | 1 | 0: data-hunt mode, 1: write-response mode |
| long_hunt | input | 1 | In data-hunt mode, selects the LONG_WIN window instead of SHORT_WIN |
| in_valid | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte |
| done | output | 1 | A result is available |
| found | output | 1 | A marker was located and accepted |
| err | output | 1 | The window ended without an accepted marker |
| tag_idx | output | IDX_W (7) | Position of the located byte, counted from the first byte taken after `start` |
| tag_byte | output | 8 | Located marker or header byte |
| pkt_type | output | 4 | Bits 3:0 of `tag_byte` |
| status_byte | output | 8 | Byte after the header in write-response mode; 0 in data-hunt mode |

## Verification
Every result is registered. It is therefore due one clock after the rising edge that takes the deciding byte: the marker in data-hunt mode, the last window byte on a miss, or the fourth byte of a write response. The clearing of `done` is due one clock after the `start` edge. The bench drives each byte on a falling edge and leaves it there for exactly one rising edge, then reads the outputs on the next falling edge. Each sample is therefore taken half a period after the edge that should have produced it. Where a requirement says a result must not come yet (a short window inside a long hunt, three of four response bytes), the bench samples `done` at the same falling-edge point right after the last byte it has sent.

// File: rtl/spi_tag_locator_pkg.sv
package spi_tag_locator_pkg;

  localparam logic [3:0] DATA_NIBBLE = 4'hF;
  localparam logic [3:0] RSP_NIBBLE  = 4'hC;
  localparam logic [3:0] TYPE_LAST   = 4'h3;
  localparam logic [7:0] STATUS_OK   = 8'h00;

  // upper nibble marks the start of read data
  function automatic logic is_data_tag(input logic [7:0] b);
    return b[7:4] == DATA_NIBBLE;
  endfunction

  // upper nibble marks a write-response header
  function automatic logic is_rsp_start(input logic [7:0] b);
    return b[7:4] == RSP_NIBBLE;
  endfunction

  // header of the final packet with a clean status
  function automatic logic rsp_accept(input logic [7:0] hdr, input logic [7:0] stat);
    return (hdr[3:0] == TYPE_LAST) && (stat == STATUS_OK);
  endfunction

endpackage

// File: rtl/tl_win_ctr.sv
module tl_win_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         at_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

  assign at_last = (cnt == lim);

endmodule

// File: rtl/tl_rsp_eval.sv
module tl_rsp_eval
  import spi_tag_locator_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 7
) (
  input  logic [N-1:0][7:0] win,
  output logic              hit,
  output logic              ok,
  output logic [IW-1:0]     idx,
  output logic [7:0]        hdr,
  output logic [7:0]        stat
);

  // ascending walk, so the highest matching position is the one kept
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    hdr  = '0;
    stat = '0;
    for (int i = 0; i < N - 1; i++) begin
      if (is_rsp_start(win[i])) begin
        hit  = 1'b1;
        idx  = IW'(i);
        hdr  = win[i];
        stat = win[i+1];
      end
    end
  end

  assign ok = hit && rsp_accept(hdr, stat);

endmodule

// File: rtl/spi_tag_locator.sv
module spi_tag_locator
  import spi_tag_locator_pkg::*;
#(
  parameter int SHORT_WIN = 8,
  parameter int LONG_WIN  = 101,
  parameter int RSP_BYTES = 4,
  localparam int IDX_W    = $clog2(LONG_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_mode,
  input  logic             long_hunt,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             done,
  output logic             found,
  output logic             err,
  output logic [IDX_W-1:0] tag_idx,
  output logic [7:0]       tag_byte,
  output logic [3:0]       pkt_type,
  output logic [7:0]       status_byte
);

  logic             busy_q;
  logic             mode_wr_q;
  logic [IDX_W-1:0] lim_q;
  logic [IDX_W-1:0] cnt;
  logic             at_last;
  logic [7:0]       cap_q [RSP_BYTES-1];

  // named events
  logic byte_take, data_hit, finish;
  assign byte_take = busy_q && in_valid && !start;
  assign data_hit  = byte_take && !mode_wr_q && is_data_tag(in_byte);
  assign finish    = byte_take && (data_hit || at_last);

  tl_win_ctr #(.W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(byte_take && !finish),
    .lim(lim_q), .cnt(cnt), .at_last(at_last)
  );

  // write-response window: stored bytes plus the live last byte
  logic [RSP_BYTES-1:0][7:0] rsp_win;
  for (genvar g = 0; g < RSP_BYTES - 1; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q[g] <= '0;
      else if (start)  cap_q[g] <= '0;
      else if (byte_take && mode_wr_q && cnt == IDX_W'(g)) cap_q[g] <= in_byte;
    end
    assign rsp_win[g] = cap_q[g];
  end
  assign rsp_win[RSP_BYTES-1] = in_byte;

  logic             ev_hit, ev_ok;
  logic [IDX_W-1:0] ev_idx;
  logic [7:0]       ev_hdr, ev_stat;

  tl_rsp_eval #(.N(RSP_BYTES), .IW(IDX_W)) u_eval (
    .win(rsp_win), .hit(ev_hit), .ok(ev_ok),
    .idx(ev_idx), .hdr(ev_hdr), .stat(ev_stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; mode_wr_q <= 1'b0; lim_q <= '0;
      done <= 1'b0; found <= 1'b0; err <= 1'b0;
      tag_idx <= '0; tag_byte <= '0; status_byte <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      mode_wr_q <= wr_mode;
      lim_q     <= wr_mode   ? IDX_W'(RSP_BYTES - 1) :
                   long_hunt ? IDX_W'(LONG_WIN - 1) : IDX_W'(SHORT_WIN - 1);
      done <= 1'b0; found <= 1'b0; err <= 1'b0;
      tag_idx <= '0; tag_byte <= '0; status_byte <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
      done   <= 1'b1;
      if (mode_wr_q) begin
        found       <= ev_ok;
        err         <= !ev_ok;
        tag_idx     <= ev_idx;
        tag_byte    <= ev_hdr;
        status_byte <= ev_stat;
      end else begin
        found    <= data_hit;
        err      <= !data_hit;
        tag_idx  <= data_hit ? cnt : '0;
        tag_byte <= data_hit ? in_byte : '0;
      end
    end
  end

  assign pkt_type = tag_byte[3:0];

endmodule

// File: rtl/spi_tag_locator_chk.sv
module spi_tag_locator_chk #(
  parameter int RSP_BYTES = 4,
  parameter int IW        = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          found,
  input logic          err,
  input logic [IW-1:0] tag_idx,
  input logic [7:0]    tag_byte,
  input logic [3:0]    pkt_type,
  input logic [7:0]    status_byte,
  input logic          mode_wr,
  input logic [IW-1:0] win_last
);

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found ^ err));

  assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!found && !err));

  assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(found) && $stable(err) && $stable(tag_idx)
                          && $stable(tag_byte) && $stable(status_byte)));

  assert_data_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found && !mode_wr) |-> (tag_byte[7:4] == 4'hF && status_byte == 8'h00));

  assert_wr_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found && mode_wr) |-> (tag_byte[7:4] == 4'hC && pkt_type == 4'h3
                                    && status_byte == 8'h00));

  assert_hdr_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_wr) |-> (tag_idx <= IW'(RSP_BYTES - 2)));

  assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_wr) |-> (tag_idx <= win_last));

endmodule

bind spi_tag_locator spi_tag_locator_chk #(.RSP_BYTES(RSP_BYTES), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .found(found), .err(err),
  .tag_idx(tag_idx), .tag_byte(tag_byte), .pkt_type(pkt_type),
  .status_byte(status_byte), .mode_wr(mode_wr_q), .win_last(lim_q)
);

// File: tb/spi_tag_locator_tb.sv
module spi_tag_locator_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, wr_mode = 1'b0, long_hunt = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       done, found, err;
  logic [6:0] tag_idx;
  logic [7:0] tag_byte, status_byte;
  logic [3:0] pkt_type;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_tag_locator u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode), .long_hunt(long_hunt),
    .in_valid(in_valid), .in_byte(in_byte), .done(done), .found(found), .err(err),
    .tag_idx(tag_idx), .tag_byte(tag_byte), .pkt_type(pkt_type), .status_byte(status_byte)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  n;
    logic [63:0] bytes;   // byte k in bits 8k+7:8k
    logic        f;
    logic        e;
    logic [7:0]  idx;
    logic [7:0]  tag;
    logic [7:0]  stat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd4, 64'h0000_0000_55F3_0000, 1'b1, 1'b0, 8'd2, 8'hF3, 8'h00},
    '{1'b0, 4'd1, 64'h0000_0000_0000_00F3, 1'b1, 1'b0, 8'd0, 8'hF3, 8'h00},
    '{1'b0, 4'd8, 64'hF100_0000_0000_0000, 1'b1, 1'b0, 8'd7, 8'hF1, 8'h00},
    '{1'b0, 4'd8, 64'h0000_0000_3FE3_1200, 1'b0, 1'b1, 8'd0, 8'h00, 8'h00},
    '{1'b1, 4'd4, 64'h0000_0000_0000_00C3, 1'b1, 1'b0, 8'd0, 8'hC3, 8'h00},
    '{1'b1, 4'd4, 64'h0000_0000_00C3_00C2, 1'b1, 1'b0, 8'd2, 8'hC3, 8'h00},
    '{1'b1, 4'd4, 64'h0000_0000_00C1_00C3, 1'b0, 1'b1, 8'd2, 8'hC1, 8'h00},
    '{1'b1, 4'd4, 64'h0000_0000_0005_C300, 1'b0, 1'b1, 8'd1, 8'hC3, 8'h05},
    '{1'b1, 4'd4, 64'h0000_0000_C300_0000, 1'b0, 1'b1, 8'd0, 8'h00, 8'h00},
    '{1'b1, 4'd4, 64'h0000_0000_4433_2211, 1'b0, 1'b1, 8'd0, 8'h00, 8'h00},
    '{1'b1, 4'd4, 64'h0000_0000_00C3_00C3, 1'b1, 1'b0, 8'd2, 8'hC3, 8'h00}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_op(input logic wr, input logic lng);
    @(negedge clk);
    start = 1'b1; wr_mode = wr; long_hunt = lng; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_result(input string req, input logic f, input logic e,
                            input logic [7:0] idx, input logic [7:0] tag, input logic [7:0] st);
    chk(req, "done", 32'(done), 32'd1);
    chk(req, "found", 32'(found), 32'(f));
    chk(req, "err", 32'(err), 32'(e));
    chk(req, "tag_idx", 32'(tag_idx), 32'(idx));
    chk(req, "tag_byte", 32'(tag_byte), 32'(tag));
    chk(req, "pkt_type", 32'(pkt_type), 32'(tag[3:0]));
    chk(req, "status_byte", 32'(status_byte), 32'(st));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", 32'(done), 0);
    chk("R1", "found", 32'(found), 0);
    chk("R1", "err", 32'(err), 0);
    chk("R1", "tag_idx", 32'(tag_idx), 0);
    chk("R1", "tag_byte", 32'(tag_byte), 0);
    chk("R1", "status_byte", 32'(status_byte), 0);
    // R10: bytes before any start are ignored
    send_byte(8'hF3);
    chk("R10", "done idle", 32'(done), 0);

    // table walk: R2 R3 R4 (data) and R8 R9 (write response)
    for (int v = 0; v < NV; v++) begin
      start_op(VECS[v].wr, 1'b0);
      for (int k = 0; k < int'(VECS[v].n); k++) send_byte(VECS[v].bytes[8*k +: 8]);
      chk_result(VECS[v].wr ? "R8_R9" : "R2_R3_R4", VECS[v].f, VECS[v].e,
                 VECS[v].idx, VECS[v].tag, VECS[v].stat);
    end

    // R10: extra bytes after a result change nothing
    send_byte(8'hF5); send_byte(8'hC3);
    chk_result("R10", 1'b1, 1'b0, 8'd2, 8'hC3, 8'h00);

    // R11: start clears, and a byte in the start cycle is not taken
    @(negedge clk);
    start = 1'b1; wr_mode = 1'b0; long_hunt = 1'b0; in_valid = 1'b1; in_byte = 8'hF3;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk("R11", "done after start", 32'(done), 0);
    send_byte(8'h00); send_byte(8'hF4);
    chk_result("R11", 1'b1, 1'b0, 8'd1, 8'hF4, 8'h00);

    // R11: restart in the middle of a hunt
    start_op(1'b0, 1'b0);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    start_op(1'b0, 1'b0);
    send_byte(8'hFA);
    chk_result("R11", 1'b1, 1'b0, 8'd0, 8'hFA, 8'h00);

    // R6: invalid cycles carry a tag-looking byte but are not taken
    start_op(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b0; in_byte = 8'hF0;
      @(negedge clk);
      send_byte(k == 3 ? 8'hF5 : 8'h00);
    end
    chk_result("R6", 1'b1, 1'b0, 8'd3, 8'hF5, 8'h00);

    // R7: three response bytes give no result, the fourth does
    start_op(1'b1, 1'b0);
    send_byte(8'hC3); send_byte(8'h00); send_byte(8'h00);
    chk("R7", "done after 3 bytes", 32'(done), 0);
    send_byte(8'h00);
    chk_result("R7", 1'b1, 1'b0, 8'd0, 8'hC3, 8'h00);

    // R5: long hunt passes the short window, tag at the last position
    start_op(1'b0, 1'b1);
    for (int k = 0; k < 8; k++) send_byte(8'h00);
    chk("R5", "done after 8 bytes", 32'(done), 0);
    for (int k = 8; k < 100; k++) send_byte(8'h00);
    send_byte(8'hF7);
    chk_result("R5", 1'b1, 1'b0, 8'd100, 8'hF7, 8'h00);

    // R5: long hunt gives up after 101 bytes
    start_op(1'b0, 1'b1);
    for (int k = 0; k < 100; k++) send_byte(8'h30);
    chk("R5", "done after 100 bytes", 32'(done), 0);
    send_byte(8'h30);
    chk_result("R5", 1'b0, 1'b1, 8'd0, 8'h00, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule